// File: doc/BRIEF.md
# Palette pixel decoder

This block takes a stream of frame-buffer bytes and turns it into 16-bit pixels. The stream may start with a palette header of 16-bit entries. The first header entry also carries a three-bit depth code. That code sets the pixel size and the length of the header. Pixels narrower than 16 bits are indices into a 256-entry palette held inside the block. 16-bit pixels are passed through as they are.

Both sides use valid/ready handshakes. A two-bit load mode is sampled when a frame starts. It selects one of three frame types: a full frame with a header and pixels, a palette-only update, or pixels that reuse the palette and depth code kept from earlier frames. The frame size is given as a width and a height, and the block emits exactly their product in pixels.

Top module: `palette_pixel_decoder`

## Requirements
- R1: During and right after reset, out_valid and in_ready are low, and every palette entry and the stored depth code are zero.
- R2: When load_mode is 0 or 3, the frame opens with a header of 512 bytes if the depth code is 3 to 7, and 32 bytes if it is 0 to 2. The first pixel byte follows the last header byte directly.
- R3: Header entry k is built from header byte 2k as the low half and byte 2k+1 as the high half. The depth code is bits 14:12 of entry 0. Entries that a short header does not reach keep their old values.
- R4: Depth code 1 packs four 2-bit indices per byte, starting from bits 1:0. Each index is output as the palette entry it addresses.
- R5: Depth code 2 packs two 4-bit indices per byte, with bits 3:0 first. Each index is output as the palette entry it addresses.
- R6: Depth code 3 uses each byte as an 8-bit palette index.
- R7: Depth codes 4 to 7 take two bytes per pixel, low byte first, and output the 16-bit value unchanged.
- R8: A frame yields exactly frame_w times frame_h pixels, and both must be at least 1. Unused indices left in the last pixel byte are dropped. The next byte accepted starts a new frame.
- R9: When load_mode is 1, the header is loaded as in R2 and R3, no pixel is emitted, and the block then waits for the next frame.
- R10: When load_mode is 2, there is no header. Pixels start at the first byte and use the stored palette and depth code.
- R11: With depth code 0, a header frame loads its 32-byte header and emits no pixel. A load_mode 2 frame accepts no byte while the stored code is 0.
- R12: While out_valid is high and out_ready is low, out_valid stays high and out_pixel does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_mode | input | 2 | Frame type, sampled when a frame starts |
| frame_w | input | DIM_W | Frame width in pixels, sampled when a frame starts |
| frame_h | input | DIM_W | Frame height in pixels, sampled when a frame starts |
| in_valid | input | 1 | A byte is offered |
| in_byte | input | 8 | Frame-buffer byte |
| in_ready | output | 1 | The block accepts the byte this cycle |
| out_valid | output | 1 | A pixel is offered |
| out_pixel | output | 16 | Output pixel |
| out_ready | input | 1 | The downstream side takes the pixel |

## Verification
The bench builds the block with DIM_W set to 4. This keeps every frame at 225 pixels or fewer, so one run can cover all depth codes, all four load modes and both header lengths, including 512-byte headers that are much longer than the pixel data after them. The small sizes also make room for frames whose pixel count is not a multiple of the indices per byte. Those frames show that the leftover bits are dropped and that the following header lines up on the next byte. One 15 by 15 frame runs with uneven output stalls to exercise the hold behaviour.

// File: rtl/ppd_pkg.sv
// Package: shared types and constants for the palette pixel decoder.
// Assumes 8-bit input bytes, 16-bit pixels and a 256-entry palette.
package ppd_pkg;
    localparam int BYTE_W    = 8;
    localparam int PIX_W     = 16;
    localparam int PAL_N     = 256;
    localparam int PAL_AW    = $clog2(PAL_N);
    localparam int HDR_CNT_W = 9;
    localparam int HDR_SHORT = 32;
    localparam int HDR_LONG  = 512;

    typedef enum logic [2:0] {DEP_NONE, DEP_2, DEP_4, DEP_8, DEP_16} depth_e;
    typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PIX} state_e;

    // Map the three-bit depth code to a pixel depth.
    function automatic depth_e depth_of(input logic [2:0] code);
        case (code)
            3'd0:    return DEP_NONE;
            3'd1:    return DEP_2;
            3'd2:    return DEP_4;
            3'd3:    return DEP_8;
            default: return DEP_16;
        endcase
    endfunction

    // Number of indices carried by one byte (zero for 16-bit or none).
    function automatic logic [2:0] per_byte(input depth_e d);
        case (d)
            DEP_2:   return 3'd4;
            DEP_4:   return 3'd2;
            DEP_8:   return 3'd1;
            default: return 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/ppd_palette.sv
// Palette store: ENTRIES words, one synchronous write port and one
// combinational read port. Assumes writes and reads never need the same
// word in the same cycle (header and pixel phases do not overlap).
module ppd_palette #(
    parameter int ENTRIES = 256,
    parameter int WORD    = 16,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [WORD-1:0] wr_word,
    input  logic [AW-1:0]   rd_idx,
    output logic [WORD-1:0] rd_word
);
    logic [WORD-1:0] mem [ENTRIES];

    // Clear on reset, otherwise store a header word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_word;
        end
    end

    // Index lookup.
    assign rd_word = mem[rd_idx];
endmodule

// File: rtl/ppd_unpack.sv
// Byte unpacker: splits each accepted byte into 2-, 4- or 8-bit indices,
// lowest bits first, or joins two bytes (low first) into one 16-bit value.
// Accepts a new byte only once the held one is used up. flush drops
// whatever is held. Assumes depth stays fixed while bytes are held.
module ppd_unpack
    import ppd_pkg::*;
#(
    parameter int WORD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  depth_e            depth,
    input  logic              flush,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              byte_ready,
    output logic              item_valid,
    output logic [WORD-1:0]   item_val,
    input  logic              item_take
);
    logic [WORD-1:0]   sr_q;
    logic [2:0]        cnt_q;
    logic              half_q;
    logic [BYTE_W-1:0] lo_q;
    logic              byte_fire;

    assign byte_ready = (cnt_q == 3'd0);
    assign item_valid = (cnt_q != 3'd0);
    assign byte_fire  = byte_valid && byte_ready;

    // Select the current item from the shift register by depth.
    always_comb begin
        case (depth)
            DEP_2:   item_val = {{(WORD-2){1'b0}}, sr_q[1:0]};
            DEP_4:   item_val = {{(WORD-4){1'b0}}, sr_q[3:0]};
            DEP_8:   item_val = {{(WORD-8){1'b0}}, sr_q[7:0]};
            default: item_val = sr_q;
        endcase
    end

    // Load, shift or drop the held byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            half_q <= 1'b0;
            lo_q   <= '0;
        end else if (flush) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else if (byte_fire) begin
            if (depth == DEP_16) begin
                if (!half_q) begin
                    lo_q   <= byte_data;
                    half_q <= 1'b1;
                end else begin
                    sr_q   <= {byte_data, lo_q};
                    cnt_q  <= 3'd1;
                    half_q <= 1'b0;
                end
            end else begin
                sr_q  <= {{(WORD-BYTE_W){1'b0}}, byte_data};
                cnt_q <= per_byte(depth);
            end
        end else if (item_take) begin
            cnt_q <= cnt_q - 3'd1;
            case (depth)
                DEP_2:   sr_q <= sr_q >> 2;
                DEP_4:   sr_q <= sr_q >> 4;
                default: sr_q <= sr_q >> 8;
            endcase
        end
    end

    // R4
    fill_then_item_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_fire && !flush && (depth == DEP_2 || depth == DEP_4 || depth == DEP_8))
        |=> item_valid);

    // R8
    take_needs_item_chk: assert property (@(posedge clk) disable iff (!rst_n)
        item_take |-> item_valid);
endmodule

// File: rtl/palette_pixel_decoder.sv
// Palette pixel decoder top. Runs the frame sequence (idle, header,
// pixels), captures the palette from the header, drives the unpacker and
// registers the looked-up or passed-through pixel. Assumes frame_w and
// frame_h are at least 1 and stay steady while a frame starts.
module palette_pixel_decoder
    import ppd_pkg::*;
#(
    parameter int DIM_W = 10,
    localparam int CNT_W = 2 * DIM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        load_mode,
    input  logic [DIM_W-1:0]  frame_w,
    input  logic [DIM_W-1:0]  frame_h,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pixel,
    input  logic              out_ready
);
    state_e                state_q;
    logic [HDR_CNT_W-1:0]  hcnt_q;
    logic [BYTE_W-1:0]     lo_q;
    logic [2:0]            code_q;
    logic                  hdr_only_q;
    logic [CNT_W-1:0]      total_q;
    logic [CNT_W-1:0]      pcnt_q;
    logic                  out_valid_q;
    logic [PIX_W-1:0]      out_pixel_q;

    depth_e                depth;
    logic                  hdr_last;
    logic                  pal_we;
    logic [PIX_W-1:0]      pal_rd;
    logic                  u_byte_ready;
    logic                  u_item_valid;
    logic [PIX_W-1:0]      u_item_val;
    logic                  take;
    logic                  last_take;
    logic [PIX_W-1:0]      pix_next;

    assign depth     = depth_of(code_q);
    assign hdr_last  = (hcnt_q == ((code_q >= 3'd3) ? HDR_CNT_W'(HDR_LONG - 1)
                                                    : HDR_CNT_W'(HDR_SHORT - 1)));
    assign pal_we    = (state_q == ST_HDR) && in_valid && hcnt_q[0];
    assign take      = (state_q == ST_PIX) && u_item_valid && (!out_valid_q || out_ready);
    assign last_take = take && (pcnt_q == total_q - 1'b1);
    assign pix_next  = (depth == DEP_16) ? u_item_val : pal_rd;

    // Byte acceptance depends only on the frame phase and unpacker space.
    always_comb begin
        case (state_q)
            ST_HDR:  in_ready = 1'b1;
            ST_PIX:  in_ready = u_byte_ready;
            default: in_ready = 1'b0;
        endcase
    end

    ppd_palette #(.ENTRIES(PAL_N), .WORD(PIX_W)) u_palette (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pal_we),
        .wr_idx  (hcnt_q[HDR_CNT_W-1:1]),
        .wr_word ({in_byte, lo_q}),
        .rd_idx  (u_item_val[PAL_AW-1:0]),
        .rd_word (pal_rd)
    );

    ppd_unpack #(.WORD(PIX_W)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .depth      (depth),
        .flush      (last_take),
        .byte_valid (in_valid && (state_q == ST_PIX)),
        .byte_data  (in_byte),
        .byte_ready (u_byte_ready),
        .item_valid (u_item_valid),
        .item_val   (u_item_val),
        .item_take  (take)
    );

    // Frame sequencing: start, header capture and pixel counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            hcnt_q     <= '0;
            lo_q       <= '0;
            code_q     <= '0;
            hdr_only_q <= 1'b0;
            total_q    <= '0;
            pcnt_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (in_valid) begin
                    total_q    <= CNT_W'(frame_w) * CNT_W'(frame_h);
                    pcnt_q     <= '0;
                    hcnt_q     <= '0;
                    hdr_only_q <= (load_mode == 2'd1);
                    if (load_mode != 2'd2)     state_q <= ST_HDR;
                    else if (depth != DEP_NONE) state_q <= ST_PIX;
                end
                ST_HDR: if (in_valid) begin
                    hcnt_q <= hcnt_q + 1'b1;
                    if (!hcnt_q[0])        lo_q   <= in_byte;
                    if (hcnt_q == 9'd1)    code_q <= in_byte[6:4];
                    if (hdr_last)
                        state_q <= (hdr_only_q || depth == DEP_NONE) ? ST_IDLE : ST_PIX;
                end
                ST_PIX: if (take) begin
                    pcnt_q <= pcnt_q + 1'b1;
                    if (last_take) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output register with hold under backpressure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_pixel_q <= '0;
        end else if (take) begin
            out_valid_q <= 1'b1;
            out_pixel_q <= pix_next;
        end else if (out_ready) begin
            out_valid_q <= 1'b0;
        end
    end

    assign out_valid = out_valid_q;
    assign out_pixel = out_pixel_q;

    // R12
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)));

    // R9
    rise_from_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ($past(state_q) == ST_PIX));

    // R8
    pix_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PIX) |-> (pcnt_q < total_q));

    // R2
    short_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR && in_valid && hcnt_q == 9'd31 && code_q < 3'd3)
        |=> (state_q != ST_HDR));
endmodule

// File: tb/test_palette_pixel_decoder.sv
module test_palette_pixel_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  load_mode = 2'd0;
    logic [3:0]  frame_w = 4'd1;
    logic [3:0]  frame_h = 4'd1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'd0;
    logic        in_ready;
    logic        out_valid;
    logic [15:0] out_pixel;
    logic        out_ready = 1'b1;

    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    bit          timed_out = 1'b0;
    bit          bp_on = 1'b0;
    bit          prev_stall = 1'b0;
    logic [15:0] prev_pix = '0;
    int unsigned seed = 32'h1234_5678;
    int          code_m = 0;
    int          pal_m [256];
    int          bq [$];
    logic [15:0] eq [$];
    string       cur_tag = "R1";

    always #5 clk = ~clk;

    palette_pixel_decoder #(.DIM_W(4)) i_palette_pixel_decoder (
        .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .frame_w(frame_w),
        .frame_h(frame_h), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_valid(out_valid), .out_pixel(out_pixel),
        .out_ready(out_ready));

    function automatic int rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 8) & 32'hFFFF);
    endfunction

    // One clock: drive at the falling edge, sample 1 ns later.
    task automatic step();
        @(negedge clk);
        in_valid  = (bq.size() != 0);
        in_byte   = in_valid ? bq[0][7:0] : 8'd0;
        out_ready = bp_on ? ((cyc % 5) > 1) : 1'b1;
        #1;
        cyc++;
        if (prev_stall) begin
            checks++;
            if (!out_valid || out_pixel !== prev_pix) begin
                fails++;
                $display("FAIL R12: held pixel got valid=%0b %h exp valid=1 %h",
                         out_valid, out_pixel, prev_pix);
            end
        end
        prev_stall = out_valid && !out_ready;
        prev_pix   = out_pixel;
        if (in_valid && in_ready) void'(bq.pop_front());
        if (out_valid && out_ready) begin
            checks++;
            if (eq.size() == 0) begin
                fails++;
                $display("FAIL R8: extra pixel got %h exp none", out_pixel);
            end else begin
                logic [15:0] e;
                e = eq.pop_front();
                if (out_pixel !== e) begin
                    fails++;
                    $display("FAIL %s: pixel got %h exp %h", cur_tag, out_pixel, e);
                end
            end
        end
        if (cyc > 150000 && !timed_out) begin
            timed_out = 1'b1;
            checks++;
            fails++;
            $display("FAIL R8: watchdog expired at cycle %0d exp below 150000", cyc);
        end
    endtask

    // Build a header and update the palette model (R2, R3).
    task automatic push_header(input int code);
        int nb;
        nb = (code >= 3) ? 512 : 32;
        for (int k = 0; k < nb / 2; k++) begin
            int w;
            w = rnd16();
            if (k == 0) w = (w & 16'h8FFF) | (code << 12);
            pal_m[k] = w;
            bq.push_back(w & 255);
            bq.push_back((w >> 8) & 255);
        end
        code_m = code;
    endtask

    // Pixel bytes and expected output (R4 to R7).
    task automatic push_pixels(input int bpp, input int n);
        if (bpp == 16) begin
            for (int i = 0; i < n; i++) begin
                int w;
                w = rnd16();
                bq.push_back(w & 255);
                bq.push_back((w >> 8) & 255);
                eq.push_back(16'(w));
            end
        end else begin
            int ppb;
            int bytes [$];
            ppb = 8 / bpp;
            for (int b = 0; b < (n + ppb - 1) / ppb; b++) begin
                int v;
                v = rnd16() & 255;
                bytes.push_back(v);
                bq.push_back(v);
            end
            for (int i = 0; i < n; i++) begin
                int idx;
                idx = (bytes[i / ppb] >> ((i % ppb) * bpp)) & ((1 << bpp) - 1);
                eq.push_back(16'(pal_m[idx]));
            end
        end
    endtask

    task automatic frame(input int mode, input int code, input int w, input int h,
                         input string tag, input bit bp);
        int bpp;
        load_mode = 2'(mode);
        frame_w   = 4'(w);
        frame_h   = 4'(h);
        bp_on     = bp;
        cur_tag   = tag;
        if (mode != 2) push_header(code);
        case (code_m)
            0: bpp = 0;
            1: bpp = 2;
            2: bpp = 4;
            3: bpp = 8;
            default: bpp = 16;
        endcase
        if (mode != 1 && bpp != 0) push_pixels(bpp, w * h);
        while ((bq.size() != 0 || eq.size() != 0) && !timed_out) step();
        repeat (8) step();
        checks++;
        if (eq.size() != 0 || bq.size() != 0) begin
            fails++;
            $display("FAIL %s: left over pixels %0d bytes %0d exp 0 0", tag, eq.size(), bq.size());
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) pal_m[i] = 0;
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset out_valid=%0b in_ready=%0b exp 0 0", out_valid, in_ready);
        end
        rst_n = 1'b1;
        step();
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
            fails++;
            $display("FAIL R1: after reset out_valid=%0b in_ready=%0b exp 0 0", out_valid, in_ready);
        end
        frame(0, 1, 5, 3, "R4 R8", 1'b0);
        frame(0, 2, 7, 1, "R5 R3", 1'b0);
        frame(0, 3, 6, 4, "R6 R2", 1'b0);
        frame(3, 5, 4, 3, "R7 R2", 1'b0);
        frame(0, 1, 3, 1, "R4 R8", 1'b1);
        frame(1, 3, 9, 9, "R9", 1'b0);
        frame(2, 0, 9, 2, "R10", 1'b0);
        frame(2, 0, 3, 3, "R10", 1'b1);
        frame(0, 0, 5, 5, "R11", 1'b0);
        checks++;
        if (in_ready !== 1'b0) begin
            fails++;
            $display("FAIL R11: in_ready after code 0 header got %0b exp 0", in_ready);
        end
        // Stored code is 0: a load_mode 2 frame must take no byte (R11).
        load_mode = 2'd2;
        bq.push_back(8'hA5);
        for (int i = 0; i < 20; i++) begin
            step();
            checks++;
            if (in_ready !== 1'b0 || out_valid !== 1'b0) begin
                fails++;
                $display("FAIL R11: mode 2 code 0 in_ready=%0b out_valid=%0b exp 0 0",
                         in_ready, out_valid);
            end
        end
        bq.delete();
        step();
        frame(0, 7, 15, 15, "R7 R12", 1'b1);
        frame(0, 3, 15, 2, "R6 R12", 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule